// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits behind the command pins of a double-data-rate SDRAM device model or protocol monitor. On each rising clock edge it samples chip select, the row strobe, the column strobe, write enable, the bank-select bits and the address bus. It turns them into one decoded command: no-operation, activate, precharge, precharge-all, read, write or mode-register load.

Alongside the decode it keeps, for each bank, an open or idle flag and the row that was opened. Address bit 8 is treated as a flag. On a read or write it asks for auto-precharge, and on a precharge it widens the precharge to every bank. The column address is assembled around that bit. Commands that break the open/idle rules are reported and dropped.

Clock enable is registered, so a low level freezes the whole block one edge after it is sampled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While chip select (`cs_n`) is sampled high, the command is decoded as no-operation (code 0) and no bank state changes, whatever the other pins carry.
- R2: `ras_n`=0, `cas_n`=1, `we_n`=1 is an activate (code 1). It opens the bank named by `ba`.
- R3: An activate latches all 12 address bits as that bank's open row. The row appears on `open_row_o[bank*12 +: 12]` and, for that cycle, on `row_o`.
- R4: `ras_n`=0, `cas_n`=1, `we_n`=0 with address bit 8 low is a precharge (code 2). It returns only the addressed bank to idle. A precharge to a bank that is already idle is legal.
- R5: The same pin pattern with address bit 8 high is precharge-all (code 3). It returns all four banks to idle.
- R6: `ras_n`=1 and `cas_n`=0 is a read (code 4) when `we_n`=1 and a write (code 5) when `we_n`=0. `col_o` is {A9, A7..A0}, and `auto_pre_o` equals A8.
- R7: A read or write with A8 high marks its bank for auto-precharge. A `burst_done` pulse whose `burst_bank` names that bank returns it to idle. A pulse naming a bank with no pending auto-precharge has no effect.
- R8: All three strobes low is a mode-register load (code 6). `row_o` carries the opcode. `ext_mode_o` is 1 when `ba`=1 (extended register) and 0 when `ba`=0.
- R9: If `cke` is sampled low at an edge, that edge still takes effect. Every later edge holds all outputs and bank state, up to and including the edge at which `cke` is first sampled high again.
- R10: An activate to an open bank, or a read or write to an idle bank, is reported as code 0 with `illegal_o`=1, and bank state is unchanged.
- R11: After reset, the command is code 0, `illegal_o` is 0 and all banks are idle.
- R12: All other pin patterns, such as refresh (`ras_n`=0, `cas_n`=0, `we_n`=1), decode to code 0 with `illegal_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address / opcode bus |
| burst_done | input | 1 | End-of-burst pulse for auto-precharge |
| burst_bank | input | 2 | Bank whose burst ended |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Bank of the decoded command |
| row_o | output | 12 | Row address or mode opcode |
| col_o | output | 9 | Column address {A9, A7..A0} |
| auto_pre_o | output | 1 | Read/write requested auto-precharge |
| ext_mode_o | output | 1 | Mode load targets the extended register |
| illegal_o | output | 1 | Command broke bank-state rules |
| bank_open_o | output | 4 | Per-bank open flag |
| open_row_o | output | 48 | Open row of each bank, bank 0 in the low bits |

## Verification
The bench builds the block with its defaults: a 12-bit row, a 9-bit column, the flag at bit 8 and four banks. With these values every bank's open flag is visible at once, and the split column field is reachable with A8 set at the same time as A9. A vector table walks activates, reads, writes, precharges, masked commands and illegal commands across several banks. Directed sequences then cover auto-precharge closure on the matching bank only, the choice between the two mode registers, and the one-edge delay of the clock-enable freeze in both directions.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_PREA = 3'd3,
        CMD_RD   = 3'd4,
        CMD_WR   = 3'd5,
        CMD_MRS  = 3'd6
    } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 8
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd,
    output logic [COL_W-1:0]  col,
    output logic              ap_flag
);
    // column field skips the flag bit
    assign col     = {addr[COL_W:AP_BIT+1], addr[AP_BIT-1:0]};
    assign ap_flag = addr[AP_BIT];

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = ap_flag ? CMD_PREA : CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  cmd_e             cmd,
    input  logic             ap,
    input  logic [ROW_W-1:0] row_in,
    input  logic             close_hit,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    typedef struct packed {
        logic             open;
        logic             pend;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if ((cmd == CMD_PRE && hit) || cmd == CMD_PREA) begin
                st_d.open = 1'b0;
                st_d.pend = 1'b0;
            end else if (cmd == CMD_ACT && hit) begin
                st_d.open = 1'b1;
                st_d.pend = 1'b0;
                st_d.row  = row_in;
            end else if (close_hit && st_q.pend) begin
                st_d.open = 1'b0;
                st_d.pend = 1'b0;
            end else if ((cmd == CMD_RD || cmd == CMD_WR) && hit && ap) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;
    assign row_o  = st_q.row;
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 8,
    parameter int BANK_W = 2,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BANK_W-1:0]          ba,
    input  logic [ROW_W-1:0]           addr,
    input  logic                       burst_done,
    input  logic [BANK_W-1:0]          burst_bank,
    output logic [2:0]                 cmd_o,
    output logic [BANK_W-1:0]          bank_o,
    output logic [ROW_W-1:0]           row_o,
    output logic [COL_W-1:0]           col_o,
    output logic                       auto_pre_o,
    output logic                       ext_mode_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic              ext;
        logic              ill;
    } out_t;

    out_t out_d, out_q;
    logic cke_q;
    cmd_e raw_cmd, eff_cmd;
    logic [COL_W-1:0] dec_col;
    logic dec_ap, illegal, bank_is_open;
    logic [NUM_BANKS-1:0] open_vec;

    sdram_cmd_decode #(.ADDR_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .cmd(raw_cmd), .col(dec_col), .ap_flag(dec_ap)
    );

    assign bank_is_open = open_vec[ba];
    assign illegal = (raw_cmd == CMD_ACT && bank_is_open) ||
                     ((raw_cmd == CMD_RD || raw_cmd == CMD_WR) && !bank_is_open);
    assign eff_cmd = illegal ? CMD_NOP : raw_cmd;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .en(cke_q),
            .hit(ba == BANK_W'(b)), .cmd(eff_cmd), .ap(dec_ap), .row_in(addr),
            .close_hit(burst_done && burst_bank == BANK_W'(b)),
            .open_o(open_vec[b]), .row_o(open_row_o[b*ROW_W +: ROW_W])
        );
    end

    always_comb begin
        out_d = out_q;
        if (cke_q) begin
            out_d.cmd  = eff_cmd;
            out_d.bank = ba;
            out_d.row  = addr;
            out_d.col  = dec_col;
            out_d.ap   = (eff_cmd == CMD_RD || eff_cmd == CMD_WR) && dec_ap;
            out_d.ext  = (eff_cmd == CMD_MRS) && (ba == BANK_W'(1));
            out_d.ill  = illegal;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            cke_q <= 1'b1;
        end else begin
            out_q <= out_d;
            cke_q <= cke;
        end
    end

    assign cmd_o       = out_q.cmd;
    assign bank_o      = out_q.bank;
    assign row_o       = out_q.row;
    assign col_o       = out_q.col;
    assign auto_pre_o  = out_q.ap;
    assign ext_mode_o  = out_q.ext;
    assign illegal_o   = out_q.ill;
    assign bank_open_o = open_vec;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       cs_n,
    input logic [2:0]                 cmd_o,
    input logic [BANK_W-1:0]          bank_o,
    input logic                       illegal_o,
    input logic [NUM_BANKS-1:0]       bank_open_o,
    input logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
    AST_CS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cs_n) |=> (cmd_o == 3'd0 && !illegal_o)); // R1
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd1) |-> bank_open_o[bank_o]); // R2
    AST_PREA_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd3) |-> (bank_open_o == '0)); // R5
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cmd_o) && $stable(bank_open_o) && $stable(open_row_o))); // R9
    AST_ILLEGAL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cmd_o == 3'd0)); // R10
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(cke_q), .cs_n(cs_n), .cmd_o(cmd_o),
    .bank_o(bank_o), .illegal_o(illegal_o), .bank_open_o(bank_open_o),
    .open_row_o(open_row_o)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0, burst_bank = '0;
    logic [11:0] addr = '0;
    logic burst_done = 1'b0;
    logic [2:0] cmd_o;
    logic [1:0] bank_o;
    logic [11:0] row_o;
    logic [8:0] col_o;
    logic auto_pre_o, ext_mode_o, illegal_o;
    logic [3:0] bank_open_o;
    logic [47:0] open_row_o;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    sdram_cmd_tracker u_sdram_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .burst_done(burst_done), .burst_bank(burst_bank),
        .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .auto_pre_o(auto_pre_o), .ext_mode_o(ext_mode_o), .illegal_o(illegal_o),
        .bank_open_o(bank_open_o), .open_row_o(open_row_o)
    );

    // {cs,ras,cas,we, ba, addr, exp_cmd, exp_illegal, exp_open, req}
    localparam int NV = 13;
    localparam logic [29:0] VEC [NV] = '{
        {4'b0011, 2'd0, 12'h123, 3'd1, 1'b0, 4'b0001, 4'd2},  // R2 activate bank 0
        {4'b0011, 2'd2, 12'hABC, 3'd1, 1'b0, 4'b0101, 4'd2},  // R2 activate bank 2
        {4'b0011, 2'd0, 12'h000, 3'd0, 1'b1, 4'b0101, 4'd10}, // R10 activate to open bank
        {4'b0101, 2'd1, 12'h000, 3'd0, 1'b1, 4'b0101, 4'd10}, // R10 read to idle bank
        {4'b0101, 2'd0, 12'h0FF, 3'd4, 1'b0, 4'b0101, 4'd6},  // R6 read
        {4'b0100, 2'd2, 12'h002, 3'd5, 1'b0, 4'b0101, 4'd6},  // R6 write
        {4'b1011, 2'd1, 12'h000, 3'd0, 1'b0, 4'b0101, 4'd1},  // R1 masked activate
        {4'b0010, 2'd0, 12'h000, 3'd2, 1'b0, 4'b0100, 4'd4},  // R4 precharge bank 0
        {4'b0010, 2'd1, 12'h000, 3'd2, 1'b0, 4'b0100, 4'd4},  // R4 precharge idle bank
        {4'b0011, 2'd3, 12'hFFF, 3'd1, 1'b0, 4'b1100, 4'd2},  // R2 activate bank 3
        {4'b0010, 2'd0, 12'h100, 3'd3, 1'b0, 4'b0000, 4'd5},  // R5 precharge all
        {4'b0000, 2'd0, 12'h032, 3'd6, 1'b0, 4'b0000, 4'd8},  // R8 mode load
        {4'b0001, 2'd0, 12'h000, 3'd0, 1'b0, 4'b0000, 4'd12}  // R12 refresh pattern
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] pins, input logic [1:0] b, input logic [11:0] a);
        {cs_n, ras_n, cas_n, we_n} = pins;
        ba = b;
        addr = a;
        step();
    endtask

    task automatic burst(input logic [1:0] b);
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        burst_done = 1'b1;
        burst_bank = b;
        step();
        burst_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset state", {cmd_o, illegal_o, bank_open_o}, {3'd0, 1'b0, 4'b0000});

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29:26], VEC[i][25:24], VEC[i][23:12]);
            chk($sformatf("R%0d table row %0d", VEC[i][3:0], i),
                {cmd_o, illegal_o, bank_open_o}, VEC[i][11:4]);
        end

        drive(4'b0011, 2'd1, 12'h5A5);
        chk("R3 open row of bank 1", open_row_o[23:12], 12'h5A5);
        chk("R3 row output", row_o, 12'h5A5);
        drive(4'b0101, 2'd1, 12'h37E);
        chk("R6 read column/auto-precharge", {cmd_o, col_o, auto_pre_o}, {3'd4, 9'h17E, 1'b1});
        burst(2'd0);
        chk("R7 burst end on other bank", bank_open_o, 4'b0010);
        burst(2'd1);
        chk("R7 auto-precharge closes bank 1", bank_open_o, 4'b0000);
        drive(4'b0011, 2'd0, 12'h000);
        drive(4'b0100, 2'd0, 12'h0FF);
        chk("R6 write column", {cmd_o, col_o, auto_pre_o}, {3'd5, 9'h0FF, 1'b0});
        burst(2'd0);
        chk("R7 burst end without pending", bank_open_o, 4'b0001);
        drive(4'b0010, 2'd0, 12'h000);
        chk("R4 bank 0 closed", bank_open_o, 4'b0000);

        drive(4'b0000, 2'd1, 12'h005);
        chk("R8 extended mode load", {cmd_o, ext_mode_o, row_o}, {3'd6, 1'b1, 12'h005});
        drive(4'b0000, 2'd0, 12'h021);
        chk("R8 base mode load", {cmd_o, ext_mode_o, row_o}, {3'd6, 1'b0, 12'h021});

        cke = 1'b0;
        drive(4'b0011, 2'd2, 12'h111);
        chk("R9 edge sampling cke low still acts", {cmd_o, bank_open_o}, {3'd1, 4'b0100});
        drive(4'b0010, 2'd2, 12'h000);
        chk("R9 frozen precharge dropped", {cmd_o, bank_open_o}, {3'd1, 4'b0100});
        cke = 1'b1;
        drive(4'b0010, 2'd0, 12'h100);
        chk("R9 still frozen at cke-high edge", {cmd_o, bank_open_o}, {3'd1, 4'b0100});
        drive(4'b0010, 2'd0, 12'h100);
        chk("R9 resumed precharge all", {cmd_o, bank_open_o}, {3'd3, 4'b0000});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule